// File: doc/BRIEF.md
# Synchronized Third-Order Sinc Decimator

This block turns a single-bit delta-sigma bitstream into a stream of signed samples. It takes one bit on every rising edge of the modulator clock and runs the bits through a cascaded integrator-comb filter of order three. It emits one sample for every R input bits, where R is a power of two chosen by a ratio code. The integrators run at the bit rate with wrap-around arithmetic. The comb section runs once per decimation event, and a saturating stage then maps its result onto the output word.

Several channels can share one sync input, one clock and one ratio code. A sync pulse clears every accumulator and restarts the decimation phase, so all channels fed this way emit their samples on the same clock edge. The ratio code is captured only at sync or reset, so a change in the code never shifts the output cadence at an unknown point. After a sync the valid strobe stays low until the filter window holds only post-sync bits. If a result does not fit the output word, the sample is clamped and marked with a saturation flag.

The sample output cannot accept back-pressure, because a modulator cannot be paused. The output has no ready input. The valid strobe is a one-cycle pulse, and the sample and flag hold their values until the next pulse, so a consumer has R cycles to capture each sample.

Top module: `sinc_decimator`

## Requirements
- R1: Reset clears the sample to 0 and drives the valid strobe and the saturation flag low. Reset also selects the largest ratio, which is 2^KMAX and equals 64 by default.
- R2: Bit 1 counts as +1 and bit 0 counts as -1. Output event m carries y = sum over j of h[j]·x[mR-1-j], where h holds the 3R-2 coefficients of (1+z^-1+...+z^-(R-1))^3. Bit positions are counted from 0 at the first bit after sync or reset, and bits before position 0 count as 0. The sample is an OUT_W-bit two's-complement value, 19 bits by default.
- R3: The ratio R is 2^k, where k is the captured ratio code. Decimation event m occurs on the edge that takes in bit mR-1, and the sample registers update on that edge.
- R4: Events 1 and 2 after a sync or reset raise no valid pulse. Every event from event 3 onward raises one.
- R5: Sync is synchronous and takes priority. The bit present during the sync cycle is discarded. Sync clears the filter state, the sample, the flag and the valid strobe, and restarts the event count. Instances that share sync, clock and ratio code pulse valid on the same edges.
- R6: A change of the ratio code while sync is low has no effect on the cadence or on the sample values.
- R7: At capture, a ratio code below KMIN (1) is raised to KMIN, and a code above KMAX (6) is lowered to KMAX.
- R8: An exact result above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is replaced by that limit, and the saturation flag is set with that sample. A result exactly at -2^(OUT_W-1) passes through without the flag. With the default word width, only an all-ones window at the largest ratio saturates.
- R9: Valid is high for exactly one cycle per emitted sample. The sample and the flag do not change between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronous restart, shared by all channels |
| bit_i | input | 1 | Modulator bitstream |
| ratio_log2_i | input | CODE_W (3) | Ratio code k, giving R = 2^k, captured at sync |
| sample_o | output | OUT_W (19) | Signed decimated sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |
| sat_o | output | 1 | Set when the current sample was clamped |

## Verification
A wrong integrator or comb value shows up as a wrong sample at the first valid event that follows it. A wrong phase counter or fill counter moves the valid pulse off the mR-1 bit boundary, and this is visible within one window of R cycles. A ratio register that changes outside sync changes the spacing of the pulses within one window. A fault in the saturation path shows only on a full-scale window at the largest ratio. The bench therefore drives runs of constant ones and constant zeros at that ratio, in addition to pseudo-random streams at several ratios. It also drives a second instance with the inverted bitstream from the same sync, so any loss of alignment or any asymmetry between the two channels shows at once.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;
  localparam int DEF_ORDER = 3;
  localparam int DEF_KMIN  = 1;
  localparam int DEF_KMAX  = 6;

  // Limits a requested ratio exponent to the supported range.
  function automatic int clamp_k(int code, int kmin, int kmax);
    if (code < kmin) return kmin;
    if (code > kmax) return kmax;
    return code;
  endfunction
endpackage

// File: rtl/sinc_decim_ctrl.sv
module sinc_decim_ctrl
  import sinc_decim_pkg::*;
#(
  parameter int ORDER  = DEF_ORDER,
  parameter int KMIN   = DEF_KMIN,
  parameter int KMAX   = DEF_KMAX,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              stb_o,
  output logic              emit_o
);
  localparam int PH_W   = KMAX;
  localparam int FILL_W = $clog2(ORDER + 1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(ORDER - 1);

  logic [CODE_W-1:0] k_q;
  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   last_ph;
  logic [FILL_W-1:0] fill_q;

  always_comb begin
    last_ph = PH_W'((32'd1 << k_q) - 32'd1);
    stb_o   = (phase_q == last_ph);
    emit_o  = stb_o && (fill_q == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= CODE_W'(KMAX);
      phase_q <= '0;
      fill_q  <= '0;
    end else if (sync_i) begin
      k_q     <= CODE_W'(clamp_k(int'(code_i), KMIN, KMAX));
      phase_q <= '0;
      fill_q  <= '0;
    end else begin
      phase_q <= stb_o ? '0 : phase_q + 1'b1;
      if (stb_o && fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> $stable(k_q));
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= last_ph);
  // R7
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(k_q) >= KMIN) && (int'(k_q) <= KMAX));
endmodule

// File: rtl/sinc_decim_integ.sv
module sinc_decim_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] last_o
);
  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] acc_d [ORDER];

  // Wrap-around sums; the next value of the last stage feeds the combs.
  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign acc_d[g] = acc_q[g] + (bit_i ? ACC_W'(1) : {ACC_W{1'b1}});
    end else begin : g_next
      assign acc_d[g] = acc_q[g] + acc_d[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q[g] <= '0;
      else if (sync_i) acc_q[g] <= '0;
      else             acc_q[g] <= acc_d[g];
    end
  end

  assign last_o = acc_d[ORDER-1];
endmodule

// File: rtl/sinc_decim_comb.sv
module sinc_decim_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 20,
  parameter int OUT_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_i,
  input  logic                    stb_i,
  input  logic                    emit_i,
  input  logic signed [ACC_W-1:0] din_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    sat_o,
  output logic                    valid_o
);
  localparam int TOP_W = ACC_W - OUT_W + 1;
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] dly_q [ORDER];
  logic signed [ACC_W-1:0] diff  [ORDER];
  logic [TOP_W-1:0]        top_bits;
  logic                    fits;
  logic signed [OUT_W-1:0] clipped;

  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    if (g == 0) begin : g_first
      assign diff[g] = din_i - dly_q[g];
    end else begin : g_next
      assign diff[g] = diff[g-1] - dly_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly_q[g] <= '0;
      else if (sync_i) dly_q[g] <= '0;
      else if (stb_i)  dly_q[g] <= (g == 0) ? din_i : diff[(g == 0) ? 0 : g-1];
    end
  end

  always_comb begin
    top_bits = diff[ORDER-1][ACC_W-1 -: TOP_W];
    fits     = (&top_bits) | (~|top_bits);
    clipped  = fits ? diff[ORDER-1][OUT_W-1:0]
                    : (diff[ORDER-1][ACC_W-1] ? OUT_MIN : OUT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o <= '0;
      sat_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else if (sync_i) begin
      sample_o <= '0;
      sat_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) begin
        sample_o <= clipped;
        sat_o    <= ~fits;
      end
    end
  end

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!emit_i && !sync_i) |=> ($stable(sample_o) && $stable(sat_o)));
  // R5
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (!valid_o && sample_o == '0 && !sat_o));
  // R8
  sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> (sample_o == OUT_MAX || sample_o == OUT_MIN));
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
  import sinc_decim_pkg::*;
#(
  parameter int ORDER = DEF_ORDER,
  parameter int KMIN  = DEF_KMIN,
  parameter int KMAX  = DEF_KMAX,
  localparam int CODE_W = $clog2(KMAX + 1),
  localparam int OUT_W  = ORDER * KMAX + 1,
  localparam int ACC_W  = OUT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_i,
  input  logic                    bit_i,
  input  logic [CODE_W-1:0]       ratio_log2_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o,
  output logic                    sat_o
);
  logic                    stb;
  logic                    emit;
  logic signed [ACC_W-1:0] integ_out;

  sinc_decim_ctrl #(
    .ORDER(ORDER), .KMIN(KMIN), .KMAX(KMAX), .CODE_W(CODE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .code_i(ratio_log2_i),
    .stb_o(stb), .emit_o(emit)
  );

  sinc_decim_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_i(bit_i),
    .last_o(integ_out)
  );

  sinc_decim_comb #(.ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .stb_i(stb), .emit_i(emit),
    .din_i(integ_out), .sample_o(sample_o), .sat_o(sat_o), .valid_o(valid_o)
  );
endmodule

// File: tb/sinc_decimator_tb.sv
module sinc_decimator_tb;
  localparam int OUT_W   = 19;
  localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;
  localparam int OUT_MIN = -(1 << (OUT_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic bit_i = 1'b0;
  logic [2:0] code = 3'd6;
  logic signed [OUT_W-1:0] sample_a, sample_b;
  logic valid_a, valid_b, sat_a, sat_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int r_model;
  int idx;
  int h [0:199];
  bit hist [0:1023];
  int last_a, last_b, lsat_a, lsat_b;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  sinc_decimator u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_i(bit_i),
    .ratio_log2_i(code), .sample_o(sample_a), .valid_o(valid_a), .sat_o(sat_a)
  );

  sinc_decimator u_dut_b (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_i(~bit_i),
    .ratio_log2_i(code), .sample_o(sample_b), .valid_o(valid_b), .sat_o(sat_b)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_ratio(int c);
    int k;
    k = (c < 1) ? 1 : ((c > 6) ? 6 : c);
    r_model = 1 << k;
    for (int i = 0; i < 200; i++) h[i] = 0;
    begin
      int t2 [0:199];
      for (int i = 0; i < 200; i++) t2[i] = 0;
      for (int i = 0; i < r_model; i++)
        for (int j = 0; j < r_model; j++) t2[i+j] += 1;
      for (int i = 0; i < 2*r_model-1; i++)
        for (int j = 0; j < r_model; j++) h[i+j] += t2[i];
    end
    idx = 0;
  endtask

  function automatic int model(int m);
    int s = 0;
    for (int j = 0; j < 3*r_model-2; j++) begin
      int p = m*r_model - 1 - j;
      if (p >= 0) s += h[j] * (hist[p] ? 1 : -1);
    end
    return s;
  endfunction

  task automatic check_cycle(string req);
    bit ev;
    int m, e, ea, eb, sa, sb;
    ev = (idx > 0) && (idx % r_model == 0);
    m  = idx / r_model;
    if (ev && m >= 3) begin
      e  = model(m);
      ea = (e > OUT_MAX) ? OUT_MAX : e;
      sa = (e > OUT_MAX) ? 1 : 0;
      eb = (-e < OUT_MIN) ? OUT_MIN : ((-e > OUT_MAX) ? OUT_MAX : -e);
      sb = (-e > OUT_MAX || -e < OUT_MIN) ? 1 : 0;
      chk(valid_a == 1'b1, req, "valid_a at event", int'(valid_a), 1);
      chk(valid_b == valid_a, {req, " R5"}, "valid_b aligned", int'(valid_b), int'(valid_a));
      chk(int'(sample_a) == ea, {req, " R2"}, "sample_a", int'(sample_a), ea);
      chk(int'(sat_a) == sa, {req, " R8"}, "sat_a", int'(sat_a), sa);
      chk(int'(sample_b) == eb, {req, " R2"}, "sample_b", int'(sample_b), eb);
      chk(int'(sat_b) == sb, {req, " R8"}, "sat_b", int'(sat_b), sb);
      last_a = ea; last_b = eb; lsat_a = sa; lsat_b = sb;
    end else begin
      // R4 / R9: no pulse off-event or during fill, outputs held
      if (valid_a || valid_b)
        chk(1'b0, {req, " R4"}, "unexpected valid", int'(valid_a), 0);
      if (int'(sample_a) != last_a || int'(sat_a) != lsat_a ||
          int'(sample_b) != last_b || int'(sat_b) != lsat_b)
        chk(1'b0, {req, " R9"}, "sample held", int'(sample_a), last_a);
    end
  endtask

  task automatic step(bit b, string req);
    bit_i = b;
    @(negedge clk);
    hist[idx] = b;
    idx++;
    check_cycle(req);
  endtask

  function automatic bit lfsr_bit();
    bit b = lf[0];
    lf = (lf >> 1) ^ (lf[0] ? 16'hB400 : 16'h0000);
    return b;
  endfunction

  task automatic do_sync(int c, string req);
    code = 3'(c);
    bit_i = 1'b1;
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    set_ratio(c);
    last_a = 0; last_b = 0; lsat_a = 0; lsat_b = 0;
    chk(valid_a == 1'b0 && valid_b == 1'b0, req, "valid after sync", int'(valid_a), 0);
    chk(int'(sample_a) == 0 && sat_a == 1'b0, req, "sample after sync", int'(sample_a), 0);
  endtask

  // R1: reset state
  task automatic t_reset();
    chk(valid_a == 1'b0, "R1", "valid in reset", int'(valid_a), 0);
    chk(int'(sample_a) == 0, "R1", "sample in reset", int'(sample_a), 0);
    chk(sat_a == 1'b0, "R1", "sat in reset", int'(sat_a), 0);
  endtask

  // R1 default ratio, R8 positive full scale saturates, R3 cadence
  task automatic t_default_full_scale();
    for (int i = 0; i < 5*64; i++) step(1'b1, "R1 R3");
    chk(lsat_a == 1, "R8", "saturation seen", lsat_a, 1);
  endtask

  // R8 boundary: negative full scale is representable
  task automatic t_negative_full_scale();
    do_sync(6, "R5");
    for (int i = 0; i < 4*64; i++) step(1'b0, "R8");
    chk(last_a == OUT_MIN && lsat_a == 0, "R8", "neg limit unflagged", last_a, OUT_MIN);
  endtask

  // R2 R3 R4 pseudo-random at R=4
  task automatic t_random_r4();
    do_sync(2, "R5");
    for (int i = 0; i < 200; i++) step(lfsr_bit(), "R2 R3 R4");
  endtask

  // R6 ratio change without sync ignored
  task automatic t_ratio_ignored();
    code = 3'd5;
    for (int i = 0; i < 100; i++) step(lfsr_bit(), "R6");
  endtask

  // R7 clamping of codes
  task automatic t_clamp();
    do_sync(0, "R5");
    for (int i = 0; i < 60; i++) step(lfsr_bit(), "R7 low");
    do_sync(7, "R5");
    for (int i = 0; i < 256; i++) step(lfsr_bit(), "R7 high");
  endtask

  // R5 resync mid-window restarts phase and fill
  task automatic t_resync();
    do_sync(3, "R5");
    for (int i = 0; i < 37; i++) step(lfsr_bit(), "R5");
    do_sync(3, "R5");
    for (int i = 0; i < 80; i++) step(lfsr_bit(), "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    set_ratio(6);
    last_a = 0; last_b = 0; lsat_a = 0; lsat_b = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_default_full_scale();
    t_negative_full_scale();
    t_random_r4();
    t_ratio_ignored();
    t_clamp();
    t_resync();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule